// File: doc/BRIEF.md
# Clock Root Configuration Register Block

This block is the software-facing register file of one clock root generator. It keeps a shadow copy of every setting the clock datapath uses: the source select, the pre-divider, the counter mode and the M, N and D counter values. Software may rewrite these shadow fields freely without disturbing the running clock. When the fields are ready, software sets a commit bit in the command register. The whole shadow set is then copied in one step to the live outputs that feed the clock-switching datapath.

The commit bit stays set while the datapath moves to the new settings. The datapath confirms the move with an apply acknowledge, and the block then clears the commit bit by itself. Each shadow register has a dirty flag that shows software which settings differ from what was last committed. Shadow writes that arrive while a commit is in flight are accepted and kept for the next commit. The register bus is a plain single-cycle interface: a write takes effect at the clock edge, and read data is a combinational function of the address.

Top module: `clkroot_cfg_regs`

## Requirements
- R1: After reset every register reads 0, except command bit 31, which follows `root_off_i`. All live outputs, `root_en` and `apply_req` are 0.
- R2: Config register (offset 0x04) layout: pre-divider in bits PDIV_W-1:0, source select in bits 10:8, mode in bits 13:12. All other bits read 0.
- R3: Writes to M (0x08), N (0x0C) and D (0x10) keep only the low MND_W bits, and the bits above them read 0. Reads of an unmapped offset return 0.
- R4: A write to a shadow register sets its dirty flag in the command register (0x00): bit 4 for config, bit 5 for N, bit 6 for M, bit 7 for D. The dirty flags cannot be written over the bus.
- R5: Writing command bit 0 as 1 while no commit is pending starts a commit. From the next cycle `apply_req` is 1, command bit 0 reads 1, and the live outputs carry the shadow values. `apply_req` stays high until the datapath acknowledges.
- R6: A shadow write never changes the live outputs. This holds both when idle and when a commit is pending. Only a commit start loads them.
- R7: When `apply_ack` is 1 while a commit is pending, the commit completes. In the next cycle command bit 0 and `apply_req` are 0, and the only dirty flags left set are those of registers written after the commit started.
- R8: `apply_ack` has no effect while no commit is pending.
- R9: Command bit 1 is a read/write root enable, driven on `root_en`. Bit 31 is read-only and reflects `root_off_i`.
- R10: `live_dual_edge` is 1 exactly when the live mode equals 2.
- R11: Writing command bit 0 as 1 while a commit is pending starts no new commit and leaves the live outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| apply_ack | input | 1 | Datapath has switched to the live settings |
| root_off_i | input | 1 | Datapath reports the root clock is off |
| root_en | output | 1 | Root enable |
| apply_req | output | 1 | Commit pending, new live settings offered |
| live_pdiv | output | PDIV_W | Live pre-divider |
| live_src | output | 3 | Live source select |
| live_mode | output | 2 | Live counter mode |
| live_dual_edge | output | 1 | Live mode is dual-edge |
| live_m | output | MND_W | Live M value |
| live_n | output | MND_W | Live N value |
| live_d | output | MND_W | Live D value |

## Verification
Four properties are checked on every cycle: the live bus stays stable unless a commit starts, `apply_req` holds until it is acknowledged, `apply_req` drops after the acknowledge, and it cannot rise without a commit start. The checker also confirms that M/N/D reads never show bits above the counter width and that command bit 31 always follows `root_off_i`. Only the bench scenarios can show field placement in the config word and the dirty-flag bookkeeping across a commit with writes in flight. The same holds for the exact values loaded onto the live bus, and for the effect of a second request while one is pending.

// File: rtl/clkroot_cfg_pkg.sv
package clkroot_cfg_pkg;
  localparam int OFF_CMD = 'h00;
  localparam int OFF_CFG = 'h04;
  localparam int OFF_M   = 'h08;
  localparam int OFF_N   = 'h0C;
  localparam int OFF_D   = 'h10;

  localparam int CMD_UPD_BIT   = 0;
  localparam int CMD_ROOTEN_BIT = 1;
  localparam int CMD_DIRTY_LSB = 4;
  localparam int CFG_SRC_LSB   = 8;
  localparam int CFG_MODE_LSB  = 12;
  localparam logic [1:0] MODE_DUAL_EDGE = 2'd2;

  // dirty slot order: 0 config, 1 N, 2 M, 3 D
  function automatic int mnd_offset(input int k);
    case (k)
      0: return OFF_M;
      1: return OFF_N;
      default: return OFF_D;
    endcase
  endfunction

  function automatic int mnd_dirty_slot(input int k);
    case (k)
      0: return 2;
      1: return 1;
      default: return 3;
    endcase
  endfunction

  function automatic logic [31:0] pack_cmd(input logic pend, input logic ren,
                                           input logic [3:0] dirty, input logic roff);
    logic [31:0] w;
    w = '0;
    w[CMD_UPD_BIT] = pend;
    w[CMD_ROOTEN_BIT] = ren;
    w[CMD_DIRTY_LSB +: 4] = dirty;
    w[31] = roff;
    return w;
  endfunction

  function automatic logic [31:0] pack_cfg(input logic [31:0] pdiv, input logic [2:0] src,
                                           input logic [1:0] mode);
    logic [31:0] w;
    w = pdiv;
    w[CFG_SRC_LSB +: 3] = src;
    w[CFG_MODE_LSB +: 2] = mode;
    return w;
  endfunction
endpackage

// File: rtl/clkroot_cfg_field.sv
module clkroot_cfg_field #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         load_live,
  output logic [W-1:0] shadow,
  output logic [W-1:0] live
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      live   <= '0;
    end else begin
      if (wr_en)     shadow <= wdata;
      if (load_live) live   <= shadow;
    end
  end
endmodule

// File: rtl/clkroot_cfg_commit.sv
module clkroot_cfg_commit #(
  parameter int NSLOT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             upd_bit,
  input  logic             ren_bit,
  input  logic             apply_ack,
  input  logic [NSLOT-1:0] wr_mask,
  output logic             commit_start,
  output logic             commit_done,
  output logic             pending,
  output logic             root_en,
  output logic [NSLOT-1:0] dirty
);
  logic [NSLOT-1:0] late;
  logic [NSLOT-1:0] dirty_nxt, late_nxt;

  assign commit_start = cmd_wr & upd_bit & ~pending;
  assign commit_done  = pending & apply_ack;

  always_comb begin
    dirty_nxt = dirty | wr_mask;
    late_nxt  = pending ? (late | wr_mask) : late;
    if (commit_done) begin
      dirty_nxt = late | wr_mask;
      late_nxt  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      root_en <= 1'b0;
      dirty   <= '0;
      late    <= '0;
    end else begin
      if (commit_start)     pending <= 1'b1;
      else if (commit_done) pending <= 1'b0;
      if (cmd_wr) root_en <= ren_bit;
      dirty <= dirty_nxt;
      late  <= late_nxt;
    end
  end
endmodule

// File: rtl/clkroot_cfg_rdmux.sv
module clkroot_cfg_rdmux
  import clkroot_cfg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] cmd_word,
  input  logic [DATA_W-1:0] cfg_word,
  input  logic [DATA_W-1:0] m_word,
  input  logic [DATA_W-1:0] n_word,
  input  logic [DATA_W-1:0] d_word,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFF_CMD)) rdata = cmd_word;
    if (addr == ADDR_W'(OFF_CFG)) rdata = cfg_word;
    if (addr == ADDR_W'(OFF_M))   rdata = m_word;
    if (addr == ADDR_W'(OFF_N))   rdata = n_word;
    if (addr == ADDR_W'(OFF_D))   rdata = d_word;
  end
endmodule

// File: rtl/clkroot_cfg_regs.sv
module clkroot_cfg_regs
  import clkroot_cfg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int PDIV_W = 5,
  parameter int MND_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              apply_ack,
  input  logic              root_off_i,
  output logic              root_en,
  output logic              apply_req,
  output logic [PDIV_W-1:0] live_pdiv,
  output logic [2:0]        live_src,
  output logic [1:0]        live_mode,
  output logic              live_dual_edge,
  output logic [MND_W-1:0]  live_m,
  output logic [MND_W-1:0]  live_n,
  output logic [MND_W-1:0]  live_d
);
  localparam int NSLOT  = 4;
  localparam int NMND   = 3;
  localparam int LIVE_W = PDIV_W + 3 + 2 + NMND * MND_W;

  logic hit_cmd, hit_cfg;
  logic [NMND-1:0] hit_mnd;
  logic [NSLOT-1:0] wr_mask;
  logic commit_start, commit_done, pending;
  logic [NSLOT-1:0] dirty;
  logic rd_is_mnd, rd_is_cmd;

  logic [PDIV_W-1:0] sh_pdiv;
  logic [2:0]        sh_src;
  logic [1:0]        sh_mode;
  logic [MND_W-1:0]  sh_mnd [NMND];
  logic [MND_W-1:0]  lv_mnd [NMND];
  logic [LIVE_W-1:0] live_vec;

  assign hit_cmd = (bus_addr == ADDR_W'(OFF_CMD));
  assign hit_cfg = (bus_addr == ADDR_W'(OFF_CFG));

  always_comb begin
    wr_mask    = '0;
    wr_mask[0] = bus_wr & hit_cfg;
    for (int k = 0; k < NMND; k++)
      wr_mask[mnd_dirty_slot(k)] = bus_wr & hit_mnd[k];
  end

  clkroot_cfg_commit #(.NSLOT(NSLOT)) u_commit (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(bus_wr & hit_cmd),
    .upd_bit(bus_wdata[CMD_UPD_BIT]),
    .ren_bit(bus_wdata[CMD_ROOTEN_BIT]),
    .apply_ack(apply_ack),
    .wr_mask(wr_mask),
    .commit_start(commit_start),
    .commit_done(commit_done),
    .pending(pending),
    .root_en(root_en),
    .dirty(dirty)
  );

  clkroot_cfg_field #(.W(PDIV_W)) u_pdiv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mask[0]),
    .wdata(bus_wdata[PDIV_W-1:0]), .load_live(commit_start),
    .shadow(sh_pdiv), .live(live_pdiv));

  clkroot_cfg_field #(.W(3)) u_src (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mask[0]),
    .wdata(bus_wdata[CFG_SRC_LSB +: 3]), .load_live(commit_start),
    .shadow(sh_src), .live(live_src));

  clkroot_cfg_field #(.W(2)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mask[0]),
    .wdata(bus_wdata[CFG_MODE_LSB +: 2]), .load_live(commit_start),
    .shadow(sh_mode), .live(live_mode));

  for (genvar k = 0; k < NMND; k++) begin : g_mnd
    assign hit_mnd[k] = (bus_addr == ADDR_W'(mnd_offset(k)));
    clkroot_cfg_field #(.W(MND_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_mask[mnd_dirty_slot(k)]),
      .wdata(bus_wdata[MND_W-1:0]), .load_live(commit_start),
      .shadow(sh_mnd[k]), .live(lv_mnd[k]));
  end

  assign live_m = lv_mnd[0];
  assign live_n = lv_mnd[1];
  assign live_d = lv_mnd[2];
  assign live_dual_edge = (live_mode == MODE_DUAL_EDGE);
  assign apply_req = pending;
  assign live_vec  = {live_pdiv, live_src, live_mode, live_m, live_n, live_d};
  assign rd_is_mnd = |hit_mnd;
  assign rd_is_cmd = hit_cmd;

  clkroot_cfg_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
    .addr(bus_addr),
    .cmd_word(DATA_W'(pack_cmd(pending, root_en, dirty, root_off_i))),
    .cfg_word(DATA_W'(pack_cfg(32'(sh_pdiv), sh_src, sh_mode))),
    .m_word(DATA_W'(sh_mnd[0])),
    .n_word(DATA_W'(sh_mnd[1])),
    .d_word(DATA_W'(sh_mnd[2])),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/clkroot_cfg_chk.sv
module clkroot_cfg_chk #(
  parameter int LIVE_W = 21,
  parameter int DATA_W = 32,
  parameter int MND_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              apply_req,
  input logic              apply_ack,
  input logic              commit_start,
  input logic              root_off_i,
  input logic              rd_is_mnd,
  input logic              rd_is_cmd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [LIVE_W-1:0] live_vec
);
  p_live_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_start |=> $stable(live_vec));
  p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_start || (apply_req && !apply_ack)) |=> apply_req);
  p_req_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_req && apply_ack) |=> !apply_req);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply_req && !commit_start) |=> !apply_req);
  p_mnd_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_mnd |-> ((bus_rdata >> MND_W) == '0));
  p_root_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_cmd |-> (bus_rdata[DATA_W-1] == root_off_i));
endmodule

bind clkroot_cfg_regs clkroot_cfg_chk #(.LIVE_W(LIVE_W), .DATA_W(DATA_W), .MND_W(MND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .apply_req(apply_req), .apply_ack(apply_ack),
  .commit_start(commit_start), .root_off_i(root_off_i), .rd_is_mnd(rd_is_mnd),
  .rd_is_cmd(rd_is_cmd), .bus_rdata(bus_rdata), .live_vec(live_vec));

// File: tb/test_clkroot_cfg_regs.sv
module test_clkroot_cfg_regs;
  localparam int ADDR_W = 5, DATA_W = 32, PDIV_W = 5, MND_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
  logic apply_ack = 1'b0, root_off_i = 1'b0;
  logic root_en, apply_req, live_dual_edge;
  logic [PDIV_W-1:0] live_pdiv;
  logic [2:0] live_src;
  logic [1:0] live_mode;
  logic [MND_W-1:0] live_m, live_n, live_d;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clkroot_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PDIV_W(PDIV_W), .MND_W(MND_W))
    i_clkroot_cfg_regs (.*);

  // {offset, write data, expected readback}
  localparam logic [68:0] VEC [7] = '{
    {5'h04, 32'hFFFF_FFFF, 32'h0000_371F},   // R2 all fields saturated
    {5'h04, 32'h0000_2A05, 32'h0000_2205},   // R2 mixed, mode 2
    {5'h08, 32'h1234_56A5, 32'h0000_00A5},   // R3 M masked
    {5'h0C, 32'hFFFF_FF3C, 32'h0000_003C},   // R3 N masked
    {5'h10, 32'h0000_01FF, 32'h0000_00FF},   // R3 D masked
    {5'h08, 32'h0000_0007, 32'h0000_0007},   // R3 M small
    {5'h14, 32'h0000_DEAD, 32'h0000_0000}    // R3 unmapped
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic ack_pulse();
    @(negedge clk);
    apply_ack = 1'b1;
    @(negedge clk);
    apply_ack = 1'b0;
  endtask

  function automatic logic [31:0] live_word();
    return {8'h0, live_pdiv, live_src, live_mode, live_m, live_n};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 cmd", 5'h00, 32'h0);
    rd("R1 cfg", 5'h04, 32'h0);
    rd("R1 d", 5'h10, 32'h0);
    chk("R1 outputs", {live_word(), live_d, root_en, apply_req, live_dual_edge},
        32'h0);
    root_off_i = 1'b1;
    rd("R1 root off status", 5'h00, 32'h8000_0000);
    root_off_i = 1'b0;

    // R4 a single M write marks only bit 6
    wr(5'h08, 32'h0000_0011);
    rd("R4 dirty M only", 5'h00, 32'h0000_0040);
    chk("R6 live untouched by idle write", 32'(live_m), 32'h0);

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd($sformatf("R2/R3 vector %0d", i), VEC[i][68:64], VEC[i][31:0]);
    end
    rd("R4 all dirty", 5'h00, 32'h0000_00F0);
    wr(5'h00, 32'h0000_00F0);
    rd("R4 dirty not writable", 5'h00, 32'h0000_00F0);

    // R5 commit start
    wr(5'h00, 32'h0000_0001);
    chk("R5 apply_req", 32'(apply_req), 32'h1);
    chk("R5 live pdiv/src/mode", {live_pdiv, live_src, live_mode}, {22'h0, 5'd5, 3'd2, 2'd2});
    chk("R5 live m/n/d", {live_m, live_n, live_d}, {8'h0, 8'h07, 8'h3C, 8'hFF});
    chk("R10 dual edge on", 32'(live_dual_edge), 32'h1);
    rd("R5 update bit reads 1", 5'h00, 32'h0000_00F1);
    repeat (3) @(negedge clk);
    chk("R5 request held", 32'(apply_req), 32'h1);

    // R6 / R11 writes during pending
    wr(5'h04, 32'h0000_0103);
    chk("R6 live pdiv held", 32'(live_pdiv), 32'd5);
    wr(5'h00, 32'h0000_0001);
    chk("R11 live unchanged", {live_pdiv, live_src, live_mode}, {22'h0, 5'd5, 3'd2, 2'd2});

    // R7 completion
    ack_pulse();
    chk("R7 apply_req cleared", 32'(apply_req), 32'h0);
    rd("R7 late dirty kept", 5'h00, 32'h0000_0010);

    // R8 stray ack
    ack_pulse();
    chk("R8 apply_req stays low", 32'(apply_req), 32'h0);
    chk("R8 live unchanged", 32'(live_pdiv), 32'd5);

    // second commit picks up held write
    wr(5'h00, 32'h0000_0001);
    chk("R5 second commit", {live_pdiv, live_src, live_mode}, {22'h0, 5'd3, 3'd1, 2'd0});
    chk("R10 dual edge off", 32'(live_dual_edge), 32'h0);
    ack_pulse();
    rd("R7 all clean", 5'h00, 32'h0);

    // R9 root enable and status
    wr(5'h00, 32'h8000_0002);
    chk("R9 root_en", 32'(root_en), 32'h1);
    chk("R9 no commit", 32'(apply_req), 32'h0);
    root_off_i = 1'b1;
    rd("R9 status high", 5'h00, 32'h8000_0002);
    root_off_i = 1'b0;
    rd("R9 status low", 5'h00, 32'h0000_0002);
    wr(5'h00, 32'h0);
    chk("R9 root_en off", 32'(root_en), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule